// File: doc/BRIEF.md
# Memory Barrier Drain Controller

This block sits between an in-order issue stage and the load/store pipeline and carries out a full synchronization barrier. When a barrier instruction arrives, the block holds back every later instruction until two conditions are met. First, no earlier instruction can still take an exception. Second, all earlier memory work has drained. The block then signals completion for one cycle and lets issue continue.

Outstanding work is tracked by four saturating counters. Each counter goes up on an issue strobe and down on the matching retire strobe. The four counters cover:

- loads, which retire on completion;
- stores, which retire on completion;
- cache-touch hints, which retire once their address translation is done;
- instructions that have not yet passed their exception check.

A touch hint never waits for its line fill. The barrier itself puts nothing on the external bus. Its latency therefore depends only on how much earlier work is in flight when it arrives.

Top module: `mbar_drain_ctrl`

## Requirements
- R1: After synchronous reset, `stall` and `bar_done` are low and every outstanding count is zero, so a barrier issued right after reset completes one cycle after it is accepted.
- R2: `stall` is high in the same cycle a barrier is accepted. A barrier is accepted when `bar_issue` is high while no barrier is pending, or in the completion cycle of the pending one.
- R3: A barrier accepted with nothing outstanding raises `bar_done` in the next cycle, and `stall` is low in that cycle unless a new barrier is accepted there.
- R4: `bar_done` does not rise while any issued load lacks its `ld_cpl` strobe. It rises in the cycle after the last outstanding load completes.
- R5: `bar_done` does not rise while any issued store lacks its `st_cpl` strobe.
- R6: A touch hint holds the barrier only until its `tch_xlat_done` strobe. No fill or bus completion is needed for it.
- R7: An instruction counted by `chk_issue` holds the barrier until its `chk_clear` strobe.
- R8: `bar_done` is a single-cycle pulse. From acceptance until that pulse, `stall` stays high.
- R9: A barrier that arrives while another is pending is held by `stall` and is not accepted before the pending one completes. It may be accepted in the completion cycle, and it then completes on its own.
- R10: Each count saturates. An issue at the maximum count (2^CNT_W − 1) leaves it unchanged, and a retire strobe at zero leaves it at zero.
- R11: An issue and a retire strobe for the same kind in the same cycle leave that count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_issue | input | 1 | Barrier instruction presented by the issue stage |
| ld_issue | input | 1 | One load issued this cycle |
| ld_cpl | input | 1 | One load fully completed this cycle |
| st_issue | input | 1 | One store issued this cycle |
| st_cpl | input | 1 | One store fully completed this cycle |
| tch_issue | input | 1 | One cache-touch hint issued this cycle |
| tch_xlat_done | input | 1 | One touch hint finished address translation |
| chk_issue | input | 1 | One instruction issued that may still raise an exception |
| chk_clear | input | 1 | One instruction passed its exception-check point |
| stall | output | 1 | Hold all later instructions at issue |
| bar_done | output | 1 | One-cycle pulse: the barrier has completed |

## Verification
The bench builds the block with CNT_W = 2, so a count tops out at 3. Five back-to-back load issues are enough to push the load count into saturation, and the bench then checks that three completions fully drain it. The same small width keeps a wrap-around on a spurious retire at zero visible as a late completion pulse. Every barrier scenario is scored against an expected completion cycle, so any added or missing cycle of latency is caught.

// File: rtl/mbar_pkg.sv
package mbar_pkg;

    // Index of each tracked kind in the strobe and count vectors.
    typedef enum logic [1:0] {
        TRK_LD  = 2'd0,
        TRK_ST  = 2'd1,
        TRK_TCH = 2'd2,
        TRK_CHK = 2'd3
    } trk_kind_e;

    localparam int NUM_TRK = 4;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_DRAIN = 1'b1
    } seq_state_e;

    // Control outputs of the barrier sequencer.
    typedef struct packed {
        logic accept;
        logic stall;
        logic done;
    } bar_ctl_t;

endpackage

// File: rtl/mbar_sat_cnt.sv
module mbar_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         empty
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && !dec && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt   = cnt_q;
    assign empty = (cnt_q == '0);

    AST_SAT_CEIL:  assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX)); // R10
    AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0)); // R10
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/mbar_seq.sv
module mbar_seq
    import mbar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bar_req,
    input  logic     all_empty,
    output bar_ctl_t ctl
);
    seq_state_e state_q;
    logic       done_c;
    logic       accept_c;

    // Completion is decided on registered counts, so an empty pipeline
    // retires the barrier in the cycle after acceptance.
    assign done_c   = (state_q == SEQ_DRAIN) && all_empty;
    assign accept_c = bar_req && ((state_q == SEQ_IDLE) || done_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else if (accept_c) begin
            state_q <= SEQ_DRAIN;
        end else if (done_c) begin
            state_q <= SEQ_IDLE;
        end
    end

    always_comb begin
        ctl.accept = accept_c;
        ctl.done   = done_c;
        ctl.stall  = accept_c || ((state_q == SEQ_DRAIN) && !done_c);
    end

    AST_STALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && bar_req) |-> ctl.stall); // R2
    AST_STALL_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_DRAIN && !ctl.done) |-> ctl.stall); // R8
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) |-> !ctl.done); // R8
    AST_NO_NEST: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_DRAIN && !ctl.done && bar_req) |=> (state_q == SEQ_DRAIN)); // R9

endmodule

// File: rtl/mbar_drain_ctrl.sv
module mbar_drain_ctrl
    import mbar_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bar_issue,
    input  logic ld_issue,
    input  logic ld_cpl,
    input  logic st_issue,
    input  logic st_cpl,
    input  logic tch_issue,
    input  logic tch_xlat_done,
    input  logic chk_issue,
    input  logic chk_clear,
    output logic stall,
    output logic bar_done
);
    logic [NUM_TRK-1:0]            inc_vec;
    logic [NUM_TRK-1:0]            dec_vec;
    logic [NUM_TRK-1:0]            empty_vec;
    logic [NUM_TRK-1:0][CNT_W-1:0] cnt_vec;
    logic                          all_empty;
    bar_ctl_t                      ctl;

    // Bit order follows trk_kind_e: load, store, touch, exception check.
    // A touch hint retires on translation; its fill never reaches this block.
    assign inc_vec = {chk_issue, tch_issue, st_issue, ld_issue};
    assign dec_vec = {chk_clear, tch_xlat_done, st_cpl, ld_cpl};

    for (genvar k = 0; k < NUM_TRK; k++) begin : g_trk
        mbar_sat_cnt #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc_vec[k]),
            .dec   (dec_vec[k]),
            .cnt   (cnt_vec[k]),
            .empty (empty_vec[k])
        );
    end

    assign all_empty = &empty_vec;

    mbar_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .bar_req   (bar_issue),
        .all_empty (all_empty),
        .ctl       (ctl)
    );

    assign stall    = ctl.stall;
    assign bar_done = ctl.done;

    AST_DONE_LD_DRAINED:  assert property (@(posedge clk) disable iff (rst)
        bar_done |-> (cnt_vec[TRK_LD] == '0)); // R4
    AST_DONE_ST_DRAINED:  assert property (@(posedge clk) disable iff (rst)
        bar_done |-> (cnt_vec[TRK_ST] == '0)); // R5
    AST_DONE_TCH_XLATED:  assert property (@(posedge clk) disable iff (rst)
        bar_done |-> (cnt_vec[TRK_TCH] == '0)); // R6
    AST_DONE_NO_EXC:      assert property (@(posedge clk) disable iff (rst)
        bar_done |-> (cnt_vec[TRK_CHK] == '0)); // R7

endmodule

// File: tb/test_mbar_drain_ctrl.sv
module test_mbar_drain_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bar_issue = 0, ld_issue = 0, ld_cpl = 0, st_issue = 0, st_cpl = 0;
    logic tch_issue = 0, tch_xlat_done = 0, chk_issue = 0, chk_clear = 0;
    logic stall, bar_done;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int last_cyc = 0;
    logic stall_s;
    bit finished = 0;

    int    exp_cyc[$];
    string exp_req[$];

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    mbar_drain_ctrl #(.CNT_W(2)) i_mbar_drain_ctrl (
        .clk(clk), .rst(rst), .bar_issue(bar_issue),
        .ld_issue(ld_issue), .ld_cpl(ld_cpl),
        .st_issue(st_issue), .st_cpl(st_cpl),
        .tch_issue(tch_issue), .tch_xlat_done(tch_xlat_done),
        .chk_issue(chk_issue), .chk_clear(chk_clear),
        .stall(stall), .bar_done(bar_done)
    );

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cycle %0d actual=%b expected=%b", req, last_cyc, act, exp);
        end
    endtask

    // Driver: present strobes for one cycle, sample away from the edge.
    task automatic tick(input bit b, input bit li, input bit lc, input bit si, input bit sc,
                        input bit ti, input bit tx, input bit ci, input bit cc);
        bar_issue = b; ld_issue = li; ld_cpl = lc; st_issue = si; st_cpl = sc;
        tch_issue = ti; tch_xlat_done = tx; chk_issue = ci; chk_clear = cc;
        @(negedge clk);
        stall_s  = stall;
        last_cyc = cyc;
        @(posedge clk);
        #1;
        bar_issue = 0; ld_issue = 0; ld_cpl = 0; st_issue = 0; st_cpl = 0;
        tch_issue = 0; tch_xlat_done = 0; chk_issue = 0; chk_clear = 0;
    endtask

    task automatic idle();
        tick(0,0,0,0,0,0,0,0,0);
    endtask

    task automatic expect_done(input int c, input string req);
        exp_cyc.push_back(c);
        exp_req.push_back(req);
    endtask

    // Monitor: every completion pulse must match the head of the scoreboard.
    always @(negedge clk) begin
        if (!rst && bar_done === 1'b1) begin
            checks++;
            if (exp_cyc.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected bar_done at cycle %0d actual=1 expected=0", cyc);
            end else begin
                automatic int    c = exp_cyc.pop_front();
                automatic string r = exp_req.pop_front();
                if (c != cyc) begin
                    errors++;
                    $display("FAIL %s: bar_done cycle actual=%0d expected=%0d", r, cyc, c);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        last_cyc = cyc;
        chk_bit("R1 stall after reset", stall, 1'b0);
        chk_bit("R1 done after reset", bar_done, 1'b0);
        @(posedge clk);
        #1;

        // Empty barrier right after reset
        tick(1,0,0,0,0,0,0,0,0);
        chk_bit("R2 stall on accept", stall_s, 1'b1);
        expect_done(last_cyc + 1, "R1/R3 empty barrier");
        idle();
        chk_bit("R3 stall released at done", stall_s, 1'b0);
        idle();

        // Two outstanding loads
        tick(0,1,0,0,0,0,0,0,0);
        tick(0,1,0,0,0,0,0,0,0);
        tick(1,0,0,0,0,0,0,0,0);
        chk_bit("R2 stall on accept with loads", stall_s, 1'b1);
        expect_done(last_cyc + 4, "R4 loads drained");
        idle();
        chk_bit("R8 stall held while draining", stall_s, 1'b1);
        tick(0,0,1,0,0,0,0,0,0);
        tick(0,0,1,0,0,0,0,0,0);
        chk_bit("R4 stall with one load left", stall_s, 1'b1);
        idle();
        idle();

        // Stores with a same-cycle issue and completion
        tick(0,0,0,1,0,0,0,0,0);
        tick(0,0,0,1,1,0,0,0,0);
        tick(1,0,0,0,0,0,0,0,0);
        expect_done(last_cyc + 2, "R5/R11 stores drained");
        tick(0,0,0,0,1,0,0,0,0);
        chk_bit("R5 stall with store pending", stall_s, 1'b1);
        idle();
        idle();

        // Touch hint: translation alone releases it
        tick(0,0,0,0,0,1,0,0,0);
        tick(1,0,0,0,0,0,0,0,0);
        expect_done(last_cyc + 3, "R6 touch translated");
        idle();
        tick(0,0,0,0,0,0,1,0,0);
        chk_bit("R6 stall until translation", stall_s, 1'b1);
        idle();
        idle();

        // Instruction awaiting its exception check
        tick(0,0,0,0,0,0,0,1,0);
        tick(1,0,0,0,0,0,0,0,0);
        expect_done(last_cyc + 3, "R7 exception check cleared");
        idle();
        tick(0,0,0,0,0,0,0,0,1);
        chk_bit("R7 stall until check cleared", stall_s, 1'b1);
        idle();
        idle();

        // Second barrier while one is pending
        tick(0,1,0,0,0,0,0,0,0);
        tick(1,0,0,0,0,0,0,0,0);
        expect_done(last_cyc + 3, "R9 first barrier");
        tick(1,0,0,0,0,0,0,0,0);
        chk_bit("R9 second barrier held", stall_s, 1'b1);
        tick(1,0,1,0,0,0,0,0,0);
        tick(1,0,0,0,0,0,0,0,0);
        chk_bit("R9 second barrier accepted at done", stall_s, 1'b1);
        expect_done(last_cyc + 1, "R9 second barrier");
        idle();
        chk_bit("R9 stall released after second", stall_s, 1'b0);
        idle();

        // Saturation at the top: five issues, count caps at 3
        for (int i = 0; i < 5; i++) tick(0,1,0,0,0,0,0,0,0);
        tick(1,0,0,0,0,0,0,0,0);
        expect_done(last_cyc + 4, "R10 saturated count drained");
        tick(0,0,1,0,0,0,0,0,0);
        tick(0,0,1,0,0,0,0,0,0);
        tick(0,0,1,0,0,0,0,0,0);
        chk_bit("R10 stall before last completion retires", stall_s, 1'b1);
        idle();
        idle();

        // Completion strobe at zero must not wrap
        tick(0,0,1,0,0,0,0,0,0);
        tick(0,1,0,0,0,0,0,0,0);
        tick(1,0,0,0,0,0,0,0,0);
        expect_done(last_cyc + 2, "R10 floor at zero");
        tick(0,0,1,0,0,0,0,0,0);
        idle();
        idle();
        idle();

        checks++;
        if (exp_cyc.size() != 0) begin
            errors++;
            $display("FAIL R8: missing bar_done pulses actual=%0d expected=0", exp_cyc.size());
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule